// File: doc/BRIEF.md
# Dual Noise-Source Repetition Health Monitor

This block watches the raw bit streams of a pair of independent entropy sources, one bit per source on every sampling-clock cycle. For each source it runs two continuous run-length tests. The first looks for a source that is stuck at a constant level. The second looks for a source that keeps repeating the same alternating two-bit pair. If any test trips, the block raises a latched seed-error flag and withdraws its sample-enable. The generator stays stopped until the enable is dropped and raised again.

The block also enforces a warm-up interval after the enable rises. The sources are given a few sampling cycles to settle, and no bit is tested or passed on during that interval. A register block reads `seed_err`. Downstream post-processing uses `sample_en` to know when the raw bits are valid and healthy.

Top module: `noise_health_mon`

## Requirements
- R1: If any source delivers 65 equal consecutive sampled bits, `seed_err` rises at the clock edge that samples the 65th bit. A run of exactly 64 equal bits followed by a different bit raises no error.
- R2: Sampled bits of each source are grouped into non-overlapping pairs, counted from the first sampled bit. The first bit of a pair is the first bit sampled. If a source delivers 33 consecutive identical pairs that are both 01 or both 10, `seed_err` rises at the edge that completes the 33rd pair. Exactly 32 such pairs raise no error, and a stream whose pairs alternate between 01 and 10 never raises one.
- R3: Each source is tested on its own counters. A failure on `noise_bits[0]` alone, on `noise_bits[1]` alone, or on both in the same cycle raises `seed_err`.
- R4: After `enable` rises, it must be seen high at 4 rising edges before sampling starts. `sample_en` reads 1 after the 4th edge, and bits presented before the 5th edge are not tested.
- R5: Once `seed_err` is 1, it stays 1 for as long as `enable` stays high, whatever the bits do. While `seed_err` is 1, `sample_en` is 0.
- R6: A rising edge with `enable` low clears `seed_err`, all run counters and the warm-up count. This clear takes priority over a failure detected in the same cycle.
- R7: While `rst_n` is low, `seed_err` and `sample_en` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; low clears the block |
| noise_bits | input | NUM_SRC (2) | One raw bit per source; bit i belongs to source i |
| sample_en | output | 1 | Warm-up done and no error: raw bits are being sampled |
| seed_err | output | 1 | Latched health-test failure |

## Verification
Two events can fall in the same cycle: detection of a failing run and the clear caused by a low enable. The bench provokes this by driving 64 equal bits and then presenting the 65th bit in the same cycle that it lowers `enable`. It then expects `seed_err` to stay 0 after that edge. It also lets both sources fail at the same edge, expects a single latched error, and expects the error to clear on the next disable.

// File: rtl/nhm_pkg.sv
package nhm_pkg;

    localparam int NHM_NUM_SRC     = 2;
    localparam int NHM_CONST_LIMIT = 64;
    localparam int NHM_PAIR_LIMIT  = 32;
    localparam int NHM_START_DELAY = 4;

    // Pair encodings in {first_bit, second_bit} order
    localparam logic [1:0] PAIR_01 = 2'b01;
    localparam logic [1:0] PAIR_10 = 2'b10;

    function automatic logic is_alt_pair(input logic [1:0] p);
        return (p == PAIR_01) || (p == PAIR_10);
    endfunction

endpackage

// File: rtl/nhm_warmup.sv
module nhm_warmup #(
    parameter int START_DELAY = nhm_pkg::NHM_START_DELAY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic ready_o
);
    localparam int WW = $clog2(START_DELAY + 2);
    localparam logic [WW-1:0] DONE = WW'(START_DELAY);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } warm_t;

    warm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < DONE) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = (st_q.cnt == DONE);

endmodule

// File: rtl/nhm_const_run.sv
module nhm_const_run #(
    parameter int LIMIT = nhm_pkg::NHM_CONST_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic bit_i,
    output logic fail_o
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

    typedef struct packed {
        logic          have;
        logic          prev;
        logic [CW-1:0] cnt;
    } run_t;

    run_t st_d, st_q;
    logic same;

    always_comb begin
        st_d = st_q;
        same = st_q.have && (bit_i == st_q.prev);
        if (clr) begin
            st_d = '0;
        end else if (smp) begin
            if (same) begin
                if (st_q.cnt != SAT) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = CW'(1);
            end
            st_d.prev = bit_i;
            st_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the sample that would make the run longer than LIMIT
    assign fail_o = smp && !clr && same && (st_q.cnt >= LIM);

endmodule

// File: rtl/nhm_pair_run.sv
module nhm_pair_run #(
    parameter int LIMIT = nhm_pkg::NHM_PAIR_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic bit_i,
    output logic fail_o
);
    import nhm_pkg::*;

    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

    typedef struct packed {
        logic          phase;     // 1: first bit of pair held
        logic          half;
        logic          have_pair;
        logic [1:0]    last_pair;
        logic [CW-1:0] cnt;
    } pr_t;

    pr_t st_d, st_q;
    logic [1:0] pair;
    logic       repeat_alt;

    always_comb begin
        st_d       = st_q;
        pair       = {st_q.half, bit_i};
        repeat_alt = st_q.phase && st_q.have_pair &&
                     (pair == st_q.last_pair) && is_alt_pair(pair);
        if (clr) begin
            st_d = '0;
        end else if (smp) begin
            if (!st_q.phase) begin
                st_d.half  = bit_i;
                st_d.phase = 1'b1;
            end else begin
                if (repeat_alt) begin
                    if (st_q.cnt != SAT) st_d.cnt = st_q.cnt + 1'b1;
                end else begin
                    st_d.cnt = CW'(1);
                end
                st_d.last_pair = pair;
                st_d.have_pair = 1'b1;
                st_d.phase     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail_o = smp && !clr && repeat_alt && (st_q.cnt >= LIM);

endmodule

// File: rtl/noise_health_mon.sv
module noise_health_mon #(
    parameter int NUM_SRC     = nhm_pkg::NHM_NUM_SRC,
    parameter int CONST_LIMIT = nhm_pkg::NHM_CONST_LIMIT,
    parameter int PAIR_LIMIT  = nhm_pkg::NHM_PAIR_LIMIT,
    parameter int START_DELAY = nhm_pkg::NHM_START_DELAY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [NUM_SRC-1:0] noise_bits,
    output logic               sample_en,
    output logic               seed_err
);
    typedef struct packed {
        logic err;
    } top_t;

    top_t st_d, st_q;

    logic               clr;
    logic               ready;
    logic               smp;
    logic [NUM_SRC-1:0] const_fail;
    logic [NUM_SRC-1:0] pair_fail;

    assign clr = !enable;
    assign smp = enable && ready && !st_q.err;

    nhm_warmup #(.START_DELAY(START_DELAY)) u_warm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ready_o (ready)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        nhm_const_run #(.LIMIT(CONST_LIMIT)) u_const (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .smp    (smp),
            .bit_i  (noise_bits[s]),
            .fail_o (const_fail[s])
        );
        nhm_pair_run #(.LIMIT(PAIR_LIMIT)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .smp    (smp),
            .bit_i  (noise_bits[s]),
            .fail_o (pair_fail[s])
        );
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.err = 1'b0;               // clear wins (R6)
        end else if (|const_fail || |pair_fail) begin
            st_d.err = 1'b1;               // latched (R5)
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seed_err  = st_q.err;
    assign sample_en = ready && !st_q.err;

endmodule

// File: rtl/nhm_checker.sv
module nhm_checker #(
    parameter int START_DELAY = nhm_pkg::NHM_START_DELAY
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sample_en,
    input logic seed_err
);
    int en_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   en_cnt <= 0;
        else if (!enable)             en_cnt <= 0;
        else if (en_cnt < START_DELAY) en_cnt <= en_cnt + 1;
    end

    p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |-> (!seed_err && !sample_en));

    p_clear_on_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!seed_err && !sample_en));

    p_err_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_err && enable) |=> seed_err);

    p_err_blocks_sampling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err |-> !sample_en);

    p_err_only_after_sampling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seed_err) |-> $past(sample_en));

    p_warmup_respected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (en_cnt >= START_DELAY));

endmodule

bind noise_health_mon nhm_checker #(.START_DELAY(START_DELAY)) u_nhm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sample_en (sample_en),
    .seed_err  (seed_err)
);

// File: tb/test_noise_health_mon.sv
module test_noise_health_mon;

    localparam int CLK_PERIOD = 10;
    localparam int WARM       = 4;

    // pattern kinds
    localparam logic [2:0] K_ZERO = 3'd0;
    localparam logic [2:0] K_ONE  = 3'd1;
    localparam logic [2:0] K_A01  = 3'd2;
    localparam logic [2:0] K_A10  = 3'd3;
    localparam logic [2:0] K_MIX  = 3'd4;   // 0110 repeating

    typedef struct packed {
        logic [2:0]  kind;
        logic        src;
        logic [11:0] len;
        logic        exp_err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{K_ZERO, 1'b0, 12'd64,  1'b0},   // R1 boundary
        '{K_ZERO, 1'b0, 12'd65,  1'b1},   // R1
        '{K_ONE,  1'b0, 12'd65,  1'b1},   // R1
        '{K_A01,  1'b0, 12'd64,  1'b0},   // R2 boundary, 32 pairs
        '{K_A01,  1'b0, 12'd66,  1'b1},   // R2
        '{K_A10,  1'b0, 12'd66,  1'b1},   // R2
        '{K_MIX,  1'b0, 12'd200, 1'b0},   // R2 alternating pairs
        '{K_ZERO, 1'b1, 12'd65,  1'b1},   // R3 source 1
        '{K_A10,  1'b1, 12'd66,  1'b1}    // R3 source 1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] noise_bits = 2'b00;
    logic       sample_en;
    logic       seed_err;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    noise_health_mon i_noise_health_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .noise_bits (noise_bits),
        .sample_en  (sample_en),
        .seed_err   (seed_err)
    );

    function automatic logic pat(input logic [2:0] kind, input int i);
        case (kind)
            K_ZERO:  return 1'b0;
            K_ONE:   return 1'b1;
            K_A01:   return i[0];
            K_A10:   return ~i[0];
            default: return (i % 4 == 1) || (i % 4 == 2);
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic feed(input logic b0, input logic b1);
        noise_bits = {b1, b0};
        @(negedge clk);
    endtask

    // drop enable for one edge, raise it, wait out the warm-up
    task automatic restart();
        enable = 1'b0;
        noise_bits = 2'b00;
        @(negedge clk);
        enable = 1'b1;
        repeat (WARM) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R7 reset state
        repeat (3) @(negedge clk);
        chk("R7 seed_err in reset", seed_err, 1'b0);
        chk("R7 sample_en in reset", sample_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int v = 0; v < NV; v++) begin
            restart();
            for (int i = 0; i < int'(VEC[v].len); i++) begin
                if (VEC[v].src) feed(pat(K_MIX, i), pat(VEC[v].kind, i));
                else            feed(pat(VEC[v].kind, i), pat(K_MIX, i));
            end
            chk($sformatf("R1/R2/R3 vector %0d seed_err", v), seed_err, VEC[v].exp_err);
            chk($sformatf("R5 vector %0d sample_en", v), sample_en, !VEC[v].exp_err);
        end

        // R4 warm-up: zeros during warm-up are not counted
        enable = 1'b0;
        noise_bits = 2'b00;
        @(negedge clk);
        enable = 1'b1;
        repeat (WARM - 1) @(negedge clk);
        chk("R4 sample_en after 3 edges", sample_en, 1'b0);
        @(negedge clk);
        chk("R4 sample_en after 4 edges", sample_en, 1'b1);
        for (int i = 0; i < 64; i++) feed(1'b0, pat(K_MIX, i));
        chk("R4 warm-up bits ignored", seed_err, 1'b0);
        feed(1'b0, 1'b1);
        chk("R1 65th zero after warm-up", seed_err, 1'b1);

        // R5 latch
        for (int i = 0; i < 10; i++) feed(pat(K_MIX, i), pat(K_MIX, i));
        chk("R5 error held", seed_err, 1'b1);
        chk("R5 sample_en low", sample_en, 1'b0);

        // R6 clear on disable
        enable = 1'b0;
        @(negedge clk);
        chk("R6 cleared by disable", seed_err, 1'b0);
        chk("R6 sample_en low when disabled", sample_en, 1'b0);

        // R6 disable mid-run resets counters
        restart();
        for (int i = 0; i < 60; i++) feed(1'b0, pat(K_MIX, i));
        restart();
        for (int i = 0; i < 10; i++) feed(1'b0, pat(K_MIX, i));
        chk("R6 counters cleared mid-run", seed_err, 1'b0);

        // R6 clear wins over same-cycle detection
        restart();
        for (int i = 0; i < 64; i++) feed(1'b0, pat(K_MIX, i));
        enable = 1'b0;
        feed(1'b0, 1'b0);
        chk("R6 clear beats failure", seed_err, 1'b0);

        // R3 both sources fail at once
        restart();
        for (int i = 0; i < 65; i++) feed(1'b1, 1'b1);
        chk("R3 both sources fail", seed_err, 1'b1);
        enable = 1'b0;
        @(negedge clk);
        chk("R6 cleared after dual failure", seed_err, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule